// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel serial PCM stream into parallel stereo samples. Three inputs carry the stream: a bit clock, a word clock that marks which channel is being sent, and a serial data line. All three are sampled by the block's own system clock through a shared synchronizer. The block then detects bit-clock rising edges and captures one data bit at each of them.

The justification format and the word length are static configuration inputs. The slot length is never configured. A slot is whatever runs between two word-clock transitions, so bit clocks of 32, 48 and 64 times the frame rate (slots of 16, 24 and 32 bits) are all accepted as they come. Each channel word is placed MSB-first into a 24-bit output, left-aligned. Any bit of the slot that does not belong to the word is dropped.

A frame is presented as a left/right pair with a single valid pulse once its right word has ended. Both outputs keep their values until the next pulse.

Top module: `serial_audio_rx`

## Requirements
- R1: With `fmt_i` = 0 (I2S), word clock low carries the left word and high carries the right word. The MSB is the bit sampled one bit-clock period after each word-clock transition.
- R2: With `fmt_i` = 1 or 3 (left-justified), word clock high carries the left word and low the right word. The MSB is the first bit sampled after the transition.
- R3: With `fmt_i` = 2 (right-justified), the word-clock polarity is the same as in R2. The LSB is the last bit of the slot, and the MSB sits at slot length minus word length.
- R4: `wlen_i` selects the word length: 0 gives 16, 1 gives 18, 2 gives 20 and 3 gives 24 bits.
- R5: Slots of 16, 24 and 32 bit-clock periods are received correctly with no configuration change.
- R6: Slot bits outside the word have no effect on the output. For I2S and left-justified these are the trailing bits; for right-justified they are the leading bits.
- R7: A word is placed MSB-aligned at bit 23 of its output, and every bit below the word is zero.
- R8: `left_o` and `right_o` change only in the cycle where `valid_o` is high. Both carry the same frame: the left word followed by the right word that comes after it.
- R9: After reset both outputs are zero and `valid_o` is low. The first bit-clock edge after reset only primes the block. The partial slot before the first word-clock transition is discarded, so no pulse appears until a complete left slot and a complete right slot have both been received.
- R10: `valid_o` is high for exactly one system-clock cycle per frame. It rises 3 system-clock cycles after the bit-clock rising edge at which the next left slot is first seen: the first left bit for R2/R3, the second left bit for R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| wclk_i | input | 1 | Word (channel) clock, asynchronous |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Format: 0 I2S, 1 or 3 left-justified, 2 right-justified |
| wlen_i | input | 2 | Word length code (R4) |
| left_o | output | 24 | Left sample, MSB-aligned |
| right_o | output | 24 | Right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle frame strobe |

## Verification
The bench records the system-clock cycle of every bit-clock rising edge it drives. A pulse is due exactly three cycles after the edge that closes the right slot: two synchronizer stages plus the output register. The bench compares the cycle stamp of the last pulse against that figure, and separately counts that three frames give exactly three pulses. Sample values are captured at falling clock edges while the pulse is high. Once the stream stops, the bench rechecks that the last values are still held.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [1:0] {
      FMT_I2S   = 2'd0,
      FMT_LEFT  = 2'd1,
      FMT_RIGHT = 2'd2,
      FMT_LEFT2 = 2'd3
   } sar_fmt_e;

   function automatic int sar_word_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 16;
         2'd1:    return 18;
         2'd2:    return 20;
         default: return 24;
      endcase
   endfunction
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] pipe;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/sar_slot.sv
module sar_slot #(
   parameter int SH_W  = 32,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             ws,
   input  logic             sd,
   input  logic             is_i2s,
   output logic [SH_W-1:0]  shreg,
   output logic [CNT_W-1:0] idx,
   output logic             bound,
   output logic             prev_left
);
   localparam logic [CNT_W-1:0] IDX_MAX = CNT_W'(SH_W);

   logic primed;
   logic ws_d1;
   logic eff_last;
   logic eff;

   // I2S channel boundaries trail the word clock by one bit period
   assign eff       = is_i2s ? ws_d1 : ws;
   assign bound     = rise && primed && (eff != eff_last);
   assign prev_left = is_i2s ? !eff_last : eff_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed   <= 1'b0;
         ws_d1    <= 1'b0;
         eff_last <= 1'b0;
         shreg    <= '0;
         idx      <= '0;
      end else if (rise) begin
         ws_d1 <= ws;
         if (!primed) begin
            primed   <= 1'b1;
            eff_last <= ws;
         end else begin
            eff_last <= eff;
            if (eff != eff_last) begin
               shreg <= {{(SH_W-1){1'b0}}, sd};
               idx   <= CNT_W'(1);
            end else begin
               shreg <= {shreg[SH_W-2:0], sd};
               if (idx != IDX_MAX) idx <= idx + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/sar_extract.sv
module sar_extract
   import sar_pkg::*;
#(
   parameter int SH_W  = 32,
   parameter int OUT_W = 24,
   parameter int CNT_W = 6
) (
   input  logic [SH_W-1:0]  shreg,
   input  logic [CNT_W-1:0] idx,
   input  logic [1:0]       wl_code,
   input  logic             is_rj,
   output logic [OUT_W-1:0] word
);
   always_comb begin
      int n;
      int wl;
      logic [SH_W-1:0] v;
      logic [SH_W-1:0] m;
      n  = int'(idx);
      wl = sar_word_bits(wl_code);
      m  = (SH_W'(1) << wl) - SH_W'(1);
      if (is_rj)        v = shreg;
      else if (n >= wl) v = shreg >> (n - wl);
      else              v = shreg << (wl - n);
      v    = (v & m) << (OUT_W - wl);
      word = v[OUT_W-1:0];
   end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sar_pkg::*;
#(
   parameter int OUT_W       = 24,
   parameter int MAX_SLOT    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_i,
   input  logic             wclk_i,
   input  logic             sdata_i,
   input  logic [1:0]       fmt_i,
   input  logic [1:0]       wlen_i,
   output logic [OUT_W-1:0] left_o,
   output logic [OUT_W-1:0] right_o,
   output logic             valid_o
);
   localparam int CNT_W = $clog2(MAX_SLOT + 1);

   generate
      if (OUT_W < 24) begin : g_bad_out
         $error("OUT_W must hold a 24-bit word");
      end
      if (MAX_SLOT < 32 || MAX_SLOT < OUT_W) begin : g_bad_slot
         $error("MAX_SLOT must cover a 32-bit slot and OUT_W");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [2:0]          sync_q;
   logic                bclk_d;
   logic                rise;
   logic                is_i2s;
   logic                is_rj;
   logic [MAX_SLOT-1:0] shreg;
   logic [CNT_W-1:0]    idx;
   logic                bound;
   logic                prev_left;
   logic [OUT_W-1:0]    word;
   logic [OUT_W-1:0]    left_hold;
   logic                started;
   logic                left_ok;

   sar_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bclk_i, wclk_i, sdata_i}),
      .q     (sync_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_d <= 1'b0;
      else        bclk_d <= sync_q[2];
   end

   assign rise   = sync_q[2] && !bclk_d;
   assign is_i2s = (sar_fmt_e'(fmt_i) == FMT_I2S);
   assign is_rj  = (sar_fmt_e'(fmt_i) == FMT_RIGHT);

   sar_slot #(.SH_W(MAX_SLOT), .CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (rise),
      .ws        (sync_q[1]),
      .sd        (sync_q[0]),
      .is_i2s    (is_i2s),
      .shreg     (shreg),
      .idx       (idx),
      .bound     (bound),
      .prev_left (prev_left)
   );

   sar_extract #(.SH_W(MAX_SLOT), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_extract (
      .shreg   (shreg),
      .idx     (idx),
      .wl_code (wlen_i),
      .is_rj   (is_rj),
      .word    (word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started   <= 1'b0;
         left_ok   <= 1'b0;
         left_hold <= '0;
         left_o    <= '0;
         right_o   <= '0;
         valid_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (bound) begin
            if (!started) begin
               started <= 1'b1;
            end else if (prev_left) begin
               left_hold <= word;
               left_ok   <= 1'b1;
            end else if (left_ok) begin
               left_o  <= left_hold;
               right_o <= word;
               valid_o <= 1'b1;
               left_ok <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/sar_checker.sv
module sar_checker
   import sar_pkg::*;
#(
   parameter int OUT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             valid,
   input logic [OUT_W-1:0] left,
   input logic [OUT_W-1:0] right,
   input logic [1:0]       wlen,
   input logic             pend
);
   logic [OUT_W-1:0] low_mask;
   assign low_mask = (OUT_W'(1) << (OUT_W - sar_word_bits(wlen))) - OUT_W'(1);

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid); // R10
   AST_HOLD_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> $stable(left)); // R8
   AST_HOLD_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> $stable(right)); // R8
   AST_LEFT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ((left & low_mask) == '0)); // R7
   AST_RIGHT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ((right & low_mask) == '0)); // R7
   AST_NEEDS_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(pend)); // R9
endmodule

bind serial_audio_rx sar_checker #(.OUT_W(OUT_W)) u_sar_checker (
   .clk   (clk),
   .rst_n (rst_n),
   .valid (valid_o),
   .left  (left_o),
   .right (right_o),
   .wlen  (wlen_i),
   .pend  (left_ok)
);

// File: tb/serial_audio_rx_bench.sv
`timescale 1ns/1ps
module serial_audio_rx_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk_i = 1'b0;
   logic        wclk_i = 1'b0;
   logic        sdata_i = 1'b0;
   logic [1:0]  fmt_i = 2'd0;
   logic [1:0]  wlen_i = 2'd0;
   logic [23:0] left_o;
   logic [23:0] right_o;
   logic        valid_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int vcnt = 0;
   int last_vcyc = 0;
   logic [23:0] got_l [64];
   logic [23:0] got_r [64];

   logic [23:0] el [3];
   logic [23:0] er [3];
   int   g_fmt, g_S, g_wl;
   logic g_fill;

   always #4 clk = ~clk;

   serial_audio_rx u_serial_audio_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .bclk_i  (bclk_i),
      .wclk_i  (wclk_i),
      .sdata_i (sdata_i),
      .fmt_i   (fmt_i),
      .wlen_i  (wlen_i),
      .left_o  (left_o),
      .right_o (right_o),
      .valid_o (valid_o)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && valid_o) begin
         got_l[vcnt % 64] = left_o;
         got_r[vcnt % 64] = right_o;
         last_vcyc = cyc;
         vcnt = vcnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [23:0] act, input logic [23:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic int wbits(input int code);
      case (code)
         0:       return 16;
         1:       return 18;
         2:       return 20;
         default: return 24;
      endcase
   endfunction

   function automatic logic [23:0] expv(input logic [23:0] w, input int wl);
      logic [23:0] m;
      m = (24'd1 << wl) - 24'd1;
      return (w & m) << (24 - wl);
   endfunction

   function automatic logic lj_bit(input int p);
      int slot, j, fr;
      logic [23:0] w;
      logic f;
      slot = p / g_S;
      j    = p % g_S;
      fr   = slot / 2;
      if (fr < 3) begin
         w = (slot % 2 == 1) ? er[fr] : el[fr];
         f = g_fill;
      end else begin
         w = '0;
         f = 1'b0;
      end
      if (g_fmt == 2) return (j >= g_S - g_wl) ? w[g_S-1-j] : f;
      return (j < g_wl) ? w[g_wl-1-j] : f;
   endfunction

   task automatic send_bit(input logic ws, input logic d, output int rc);
      @(negedge clk);
      bclk_i  = 1'b0;
      wclk_i  = ws;
      sdata_i = d;
      repeat (4) @(negedge clk);
      bclk_i = 1'b1;
      rc = cyc;
      repeat (3) @(negedge clk);
   endtask

   task automatic apply_reset();
      rst_n   = 1'b0;
      bclk_i  = 1'b0;
      wclk_i  = 1'b0;
      sdata_i = 1'b0;
      repeat (3) @(negedge clk);
      chk(valid_o == 1'b0, "R9", "valid in reset", {23'd0, valid_o}, 24'd0);
      chk(left_o == 24'd0, "R9", "left in reset", left_o, 24'd0);
      chk(right_o == 24'd0, "R9", "right in reset", right_o, 24'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run(input string req, input int fmt, input int S, input int wlc,
                      input logic fill);
      int base, total, rc, bnd_rc;
      logic left_lvl;
      g_fmt  = fmt;
      g_S    = S;
      g_wl   = wbits(wlc);
      g_fill = fill;
      fmt_i  = fmt[1:0];
      wlen_i = wlc[1:0];
      apply_reset();
      left_lvl = (fmt == 0) ? 1'b0 : 1'b1;
      send_bit(~left_lvl, 1'b0, rc);
      base   = vcnt;
      bnd_rc = 0;
      total  = 6 * S + 2;
      for (int p = 0; p < total; p++) begin
         logic ws, d;
         ws = ((p / S) % 2 == 0) ? left_lvl : ~left_lvl;
         d  = (fmt == 0) ? ((p == 0) ? 1'b0 : lj_bit(p - 1)) : lj_bit(p);
         send_bit(ws, d, rc);
         if (p == 6 * S + ((fmt == 0) ? 1 : 0)) bnd_rc = rc;
      end
      repeat (6) @(negedge clk);
      // R9 R10: three complete frames give exactly three pulses
      chk(vcnt - base == 3, {req, " R9 R10"}, "pulse count",
          24'(vcnt - base), 24'd3);
      for (int i = 0; i < 3; i++) begin
         chk(got_l[(base + i) % 64] == expv(el[i], g_wl), {req, " R4 R7"},
             $sformatf("left frame %0d", i), got_l[(base + i) % 64], expv(el[i], g_wl));
         chk(got_r[(base + i) % 64] == expv(er[i], g_wl), {req, " R4 R7"},
             $sformatf("right frame %0d", i), got_r[(base + i) % 64], expv(er[i], g_wl));
      end
      chk(last_vcyc == bnd_rc + 3, {req, " R10"}, "pulse latency",
          24'(last_vcyc - bnd_rc), 24'd3);
      chk(left_o == expv(el[2], g_wl) && right_o == expv(er[2], g_wl), {req, " R8"},
          "held after pulse", left_o, expv(el[2], g_wl));
   endtask

   task automatic t_i2s_64fs_24();
      el = '{24'hA5C3F1, 24'h123456, 24'h800001};
      er = '{24'h7FFFFE, 24'h0F0F0F, 24'hC0FFEE};
      run("R1 R5", 0, 32, 3, 1'b1);
   endtask

   task automatic t_i2s_32fs_16();
      el = '{24'h00BEEF, 24'h008001, 24'h00FFFF};
      er = '{24'h001234, 24'h007FFE, 24'h00A55A};
      run("R1 R5", 0, 16, 0, 1'b0);
   endtask

   task automatic t_left_48fs_20();
      el = '{24'h0ABCDE, 24'h080001, 24'h0FFFFF};
      er = '{24'h012345, 24'h07FFFE, 24'h05A5A5};
      run("R2 R5 R6", 1, 24, 2, 1'b1);
   endtask

   task automatic t_left_mask_16();
      el = '{24'hFF8421, 24'hFF0001, 24'hFF7FFF};
      er = '{24'hFFF00F, 24'hFF8000, 24'hFF3C3C};
      run("R2 R6", 3, 32, 0, 1'b1);
   endtask

   task automatic t_right_32fs_16();
      el = '{24'h00CAFE, 24'h008000, 24'h000001};
      er = '{24'h00FACE, 24'h00FFFF, 24'h001111};
      run("R3 R5", 2, 16, 0, 1'b0);
   endtask

   task automatic t_right_64fs_18();
      el = '{24'h02ABCD, 24'h020001, 24'h03FFFF};
      er = '{24'h01F00F, 24'h010000, 24'h00AAAA};
      run("R3 R6", 2, 32, 1, 1'b1);
   endtask

   task automatic t_right_48fs_24();
      el = '{24'hDEADBE, 24'h800000, 24'h000001};
      er = '{24'h5A5A5A, 24'hFFFFFF, 24'h13579B};
      run("R3 R5", 2, 24, 3, 1'b0);
   endtask

   initial begin
      #(200000 * 8);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_i2s_64fs_24();
      t_i2s_32fs_16();
      t_left_48fs_20();
      t_left_mask_16();
      t_right_32fs_16();
      t_right_64fs_18();
      t_right_48fs_24();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule